// File: doc/BRIEF.md
# Window watchdog timer

The block guards a system against both stalled and runaway software. A 7-bit down-counter steps once every 2^(FIX_DIV_LOG2 + P) clock cycles, where P is a 2-bit divider select. Software must reload the counter before bit 6 drops out of it. It must also not reload too soon: a reload made while the counter still sits above a programmable window value counts as a fault. Either fault produces a one-cycle reset request, after which the block puts all of its own registers back to their power-up values.

One count before the timeout, the counter steps onto 0x40 and sets a warning flag. The warning gives firmware a last chance to save state or reload the counter. When the sticky interrupt enable is set, the flag drives a level interrupt line. Software reaches the block through a simple word-addressed write strobe and a combinational read port. Three registers are mapped: control at 0x0, configuration at 0x4 and status at 0x8. The activation bit and the interrupt enable can only be set by software; nothing but a reset clears them.

Top module: `wdg_timer`

## Requirements
- R1: After reset the control register reads 0x7F (counter 0x7F, inactive), the configuration register reads 0x07F (window 0x7F, divider select 0, interrupt enable 0), status reads 0, and `rst_req` and `irq` are low.
- R2: Register map: control at 0x0 with counter in [6:0] and activation in bit 7; configuration at 0x4 with window in [6:0], divider select in [8:7] and interrupt enable in bit 9; status at 0x8 with the warning flag in bit 0; any other offset reads 0.
- R3: The counter decrements every 2^(FIX_DIV_LOG2 + P) cycles; a control write restarts the divider, so the first step comes exactly that many cycles after the write.
- R4: When active, the step from 0x40 to 0x3F pulses `rst_req` for exactly one cycle; when inactive, the counter keeps stepping down past 0x40 with no reset request.
- R5: A control write whose counter value has bit 6 clear requests a reset on the next cycle if the block is active after the write; when inactive, the value is simply loaded.
- R6: A control write made while the current counter is greater than the window value requests a reset if the block is active after the write; a counter equal to or below the window is a legal reload.
- R7: Writing 1 to the activation bit sets it; writing 0 has no effect; only a reset clears it.
- R8: The warning flag is set when the counter steps from 0x41 to 0x40, whatever the interrupt enable; writing 0 to status bit 0 clears it, writing 1 leaves it unchanged, and a hardware set in the same cycle as a clear wins.
- R9: The interrupt enable can be set but not cleared by software; `irq` equals the warning flag ANDed with the enable.
- R10: In the cycle after a reset request, every register of the block holds its R1 value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Early-warning interrupt, level |

## Verification
The contested cycle is the one in which the counter steps onto 0x40 while software writes 0 to the warning flag. Hardware setting and software clearing then meet in the same register. The bench loads 0x41 and counts the divider period exactly, so that its status write lands on that step's edge. It then expects the flag to read 1, and to clear on a later write. The reload boundary is judged the same way: a reload with the counter exactly equal to the window must pass, while one a single count above it must produce the reset pulse.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int CNT_W  = 7;
    localparam int PSEL_W = 2;

    // counter values that carry meaning
    localparam logic [CNT_W-1:0] CNT_INIT  = 7'h7F;
    localparam logic [CNT_W-1:0] WIN_INIT  = 7'h7F;
    localparam logic [CNT_W-1:0] WARN_FROM = 7'h41;  // step from here raises the warning
    localparam logic [CNT_W-1:0] LAST_SAFE = 7'h40;  // step from here times out

    // register offsets
    localparam int OFS_CTRL = 'h0;
    localparam int OFS_CFG  = 'h4;
    localparam int OFS_STAT = 'h8;

    // field positions
    localparam int CTRL_ACT_BIT  = CNT_W;
    localparam int CFG_PSEL_LSB  = CNT_W;
    localparam int CFG_EWIE_BIT  = CNT_W + PSEL_W;
    localparam int STAT_FLAG_BIT = 0;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              act;
        logic [CNT_W-1:0]  win;
        logic [PSEL_W-1:0] psel;
        logic              ewie;
        logic              flag;
        logic              rst_req;
    } wdg_state_t;

    localparam wdg_state_t RST_STATE = '{
        cnt:     CNT_INIT,
        act:     1'b0,
        win:     WIN_INIT,
        psel:    '0,
        ewie:    1'b0,
        flag:    1'b0,
        rst_req: 1'b0
    };

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int FIX_LOG2 = 12,
    parameter int PSEL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [PSEL_W-1:0] psel,
    output logic              tick
);

    localparam int MAX_EXP = FIX_LOG2 + (1 << PSEL_W) - 1;
    localparam int PW      = MAX_EXP + 1;

    logic [PW-1:0] div_q, div_d, lim;

    always_comb begin
        lim  = (PW'(1) << (FIX_LOG2 + int'(psel))) - PW'(1);
        tick = !restart && (div_q >= lim);
        if (restart || tick) begin
            div_d = '0;
        end else begin
            div_d = div_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

endmodule

// File: rtl/wdg_refresh_judge.sv
module wdg_refresh_judge #(
    parameter int CNT_W = 7
) (
    input  logic             act_after,
    input  logic [CNT_W-1:0] cnt_now,
    input  logic [CNT_W-1:0] win,
    input  logic [CNT_W-1:0] new_cnt,
    output logic             violation
);

    logic too_early;
    logic too_low;

    always_comb begin
        too_early = cnt_now > win;
        too_low   = !new_cnt[CNT_W-1];
        violation = act_after && (too_early || too_low);
    end

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int FIX_DIV_LOG2 = 12,
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_req,
    output logic              irq
);

    localparam int USED_W = CFG_EWIE_BIT + 1;

    wdg_state_t st_q, st_d;

    logic hit_ctrl, hit_cfg, hit_stat;
    logic wr_ctrl, wr_cfg, wr_stat;
    logic act_after;
    logic violation;
    logic tick;
    logic restart;
    logic unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:USED_W];

    always_comb begin
        hit_ctrl  = addr == ADDR_W'(OFS_CTRL);
        hit_cfg   = addr == ADDR_W'(OFS_CFG);
        hit_stat  = addr == ADDR_W'(OFS_STAT);
        wr_ctrl   = wr_en && hit_ctrl;
        wr_cfg    = wr_en && hit_cfg;
        wr_stat   = wr_en && hit_stat;
        act_after = st_q.act || wdata[CTRL_ACT_BIT];
        restart   = wr_ctrl || st_q.rst_req;
    end

    wdg_prescaler #(
        .FIX_LOG2 (FIX_DIV_LOG2),
        .PSEL_W   (PSEL_W)
    ) presc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .psel    (st_q.psel),
        .tick    (tick)
    );

    wdg_refresh_judge #(
        .CNT_W (CNT_W)
    ) judge_i (
        .act_after (act_after),
        .cnt_now   (st_q.cnt),
        .win       (st_q.win),
        .new_cnt   (wdata[CNT_W-1:0]),
        .violation (violation)
    );

    // next-state logic; a later branch overrides an earlier one
    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        if (st_q.rst_req) begin
            st_d = RST_STATE;
        end else begin
            if (wr_stat) begin
                st_d.flag = st_q.flag & wdata[STAT_FLAG_BIT];
            end
            if (tick) begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
                if (st_q.cnt == WARN_FROM) begin
                    st_d.flag = 1'b1;
                end
                if (st_q.act && (st_q.cnt == LAST_SAFE)) begin
                    st_d.rst_req = 1'b1;
                end
            end
            if (wr_ctrl) begin
                st_d.act     = act_after;
                st_d.cnt     = wdata[CNT_W-1:0];
                st_d.rst_req = violation;
            end
            if (wr_cfg) begin
                st_d.win  = wdata[CNT_W-1:0];
                st_d.psel = wdata[CFG_PSEL_LSB +: PSEL_W];
                st_d.ewie = st_q.ewie || wdata[CFG_EWIE_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_ctrl) begin
            rdata[CNT_W-1:0]    = st_q.cnt;
            rdata[CTRL_ACT_BIT] = st_q.act;
        end else if (hit_cfg) begin
            rdata[CNT_W-1:0]                 = st_q.win;
            rdata[CFG_PSEL_LSB +: PSEL_W]    = st_q.psel;
            rdata[CFG_EWIE_BIT]              = st_q.ewie;
        end else if (hit_stat) begin
            rdata[STAT_FLAG_BIT] = st_q.flag;
        end
    end

    assign rst_req = st_q.rst_req;
    assign irq     = st_q.flag && st_q.ewie;

endmodule

// File: rtl/wdg_timer_chk.sv
module wdg_timer_chk
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  win_q,
    input logic              act_q,
    input logic              ewie_q,
    input logic              flag_q,
    input logic              tick,
    input logic              rst_req,
    input logic              irq
);

    logic ctrl_wr;
    assign ctrl_wr = wr_en && (addr == ADDR_W'(OFS_CTRL));

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R4

    AST_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        tick && act_q && (cnt_q == LAST_SAFE) && !rst_req |=> rst_req); // R4

    AST_LOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !rst_req && (act_q || wdata[CTRL_ACT_BIT]) && !wdata[CNT_W-1]
        |=> rst_req); // R5

    AST_EARLY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !rst_req && (act_q || wdata[CTRL_ACT_BIT]) && (cnt_q > win_q)
        |=> rst_req); // R6

    AST_ACT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act_q) |-> $past(rst_req)); // R7

    AST_WARN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (cnt_q == WARN_FROM) && !rst_req |=> flag_q); // R8

    AST_EWIE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ewie_q) |-> $past(rst_req)); // R9

    AST_CLEAN_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !irq && !act_q && (cnt_q == CNT_INIT) && (win_q == WIN_INIT)); // R10

endmodule

bind wdg_timer wdg_timer_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .cnt_q   (st_q.cnt),
    .win_q   (st_q.win),
    .act_q   (st_q.act),
    .ewie_q  (st_q.ewie),
    .flag_q  (st_q.flag),
    .tick    (tick),
    .rst_req (rst_req),
    .irq     (irq)
);

// File: tb/wdg_timer_tb.sv
`timescale 1ns/1ps
module wdg_timer_tb_top;

    localparam int FIX = 2;   // short fixed divider: step every 4 << P cycles
    localparam int AW  = 4;
    localparam int DW  = 32;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_WT = 2'd1;
    localparam logic [1:0] OP_RD = 2'd2;
    localparam logic [1:0] OP_PN = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  adr;
        logic [31:0] val;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t VECS [NV] = '{
        '{OP_WR, 4'h4, 32'h07F, 32'h0,   4'd2},  // R2 cfg: window 7F, P=0
        '{OP_WR, 4'h0, 32'h045, 32'h0,   4'd3},  // R3 load 45, divider restarts
        '{OP_WT, 4'h0, 32'd4,   32'h0,   4'd3},
        '{OP_RD, 4'h0, 32'h0,   32'h044, 4'd3},  // R3 one step after 4 cycles
        '{OP_WT, 4'h0, 32'd3,   32'h0,   4'd3},
        '{OP_RD, 4'h0, 32'h0,   32'h044, 4'd3},  // R3 no step at 7
        '{OP_WT, 4'h0, 32'd1,   32'h0,   4'd3},
        '{OP_RD, 4'h0, 32'h0,   32'h043, 4'd3},  // R3 step at 8
        '{OP_WR, 4'h4, 32'h1FF, 32'h0,   4'd3},  // R3 P=3
        '{OP_WR, 4'h0, 32'h060, 32'h0,   4'd3},
        '{OP_WT, 4'h0, 32'd31,  32'h0,   4'd3},
        '{OP_RD, 4'h0, 32'h0,   32'h060, 4'd3},  // R3 no step at 31
        '{OP_WT, 4'h0, 32'd1,   32'h0,   4'd3},
        '{OP_RD, 4'h0, 32'h0,   32'h05F, 4'd3},  // R3 step at 32
        '{OP_RD, 4'h4, 32'h0,   32'h1FF, 4'd2},  // R2 cfg fields
        '{OP_WR, 4'h4, 32'h07F, 32'h0,   4'd8},
        '{OP_WR, 4'h0, 32'h042, 32'h0,   4'd8},
        '{OP_WT, 4'h0, 32'd8,   32'h0,   4'd8},
        '{OP_RD, 4'h8, 32'h0,   32'h1,   4'd8},  // R8 flag at 40 with enable off
        '{OP_RD, 4'h0, 32'h0,   32'h040, 4'd8},
        '{OP_PN, 4'h0, 32'h0,   32'h0,   4'd9},  // R9 irq masked
        '{OP_WR, 4'h8, 32'h1,   32'h0,   4'd8},
        '{OP_RD, 4'h8, 32'h0,   32'h1,   4'd8},  // R8 writing 1 keeps flag
        '{OP_WT, 4'h0, 32'd3,   32'h0,   4'd4},
        '{OP_PN, 4'h0, 32'h0,   32'h0,   4'd4},  // R4 inactive: no reset at 3F
        '{OP_RD, 4'h0, 32'h0,   32'h03F, 4'd4},
        '{OP_WR, 4'h8, 32'h0,   32'h0,   4'd8},
        '{OP_RD, 4'h8, 32'h0,   32'h0,   4'd8},  // R8 writing 0 clears
        '{OP_WR, 4'h0, 32'h0FF, 32'h0,   4'd7},
        '{OP_RD, 4'h0, 32'h0,   32'h0FF, 4'd7},  // R7 activated
        '{OP_PN, 4'h0, 32'h0,   32'h0,   4'd6},  // R6 reload below window legal
        '{OP_WR, 4'h0, 32'h07F, 32'h0,   4'd7},
        '{OP_RD, 4'h0, 32'h0,   32'h0FF, 4'd7},  // R7 writing 0 keeps activation
        '{OP_WR, 4'h4, 32'h27F, 32'h0,   4'd9},
        '{OP_RD, 4'h4, 32'h0,   32'h27F, 4'd9},  // R9 enable set
        '{OP_WR, 4'h4, 32'h07F, 32'h0,   4'd9},
        '{OP_RD, 4'h4, 32'h0,   32'h27F, 4'd9},  // R9 enable sticky
        '{OP_RD, 4'hC, 32'h0,   32'h0,   4'd2}   // R2 unmapped offset
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rst_req;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;  // 50 MHz

    wdg_timer #(
        .FIX_DIV_LOG2 (FIX),
        .ADDR_W       (AW),
        .DATA_W       (DW)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .rst_req (rst_req),
        .irq     (irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // called just after a falling edge; the next rising edge takes the write
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        wdata = '0;
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic pins(input logic exp_irq, input logic exp_rst, input string tag);
        #1;
        chk(tag, {30'b0, irq, rst_req}, {30'b0, exp_irq, exp_rst});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wt(3);
        rst_n = 1'b1;

        // R1 power-up values
        rd(4'h0, 32'h07F, "R1 ctrl");
        rd(4'h4, 32'h07F, "R1 cfg");
        rd(4'h8, 32'h0,   "R1 status");
        pins(1'b0, 1'b0, "R1 outputs");

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                OP_WR: wr(VECS[i].adr, VECS[i].val);
                OP_WT: wt(int'(VECS[i].val));
                OP_RD: rd(VECS[i].adr, VECS[i].exp, $sformatf("R%0d vec %0d", VECS[i].req, i));
                default: pins(VECS[i].exp[1], VECS[i].exp[0],
                              $sformatf("R%0d vec %0d", VECS[i].req, i));
            endcase
        end

        // R4 R9 R10 timeout while active with the interrupt enabled
        wr(4'h0, 32'h0C2);
        wt(8);
        pins(1'b1, 1'b0, "R9 irq follows flag");
        wt(3);
        pins(1'b1, 1'b0, "R4 no reset before step");
        wt(1);
        pins(1'b1, 1'b1, "R4 reset on 40->3F");
        wt(1);
        pins(1'b0, 1'b0, "R4 pulse one cycle / R10");
        rd(4'h0, 32'h07F, "R10 ctrl restored");
        rd(4'h4, 32'h07F, "R10 cfg restored");
        rd(4'h8, 32'h0,   "R10 status restored");

        // R6 reload one count above the window
        wr(4'h0, 32'h0D0);
        wr(4'h4, 32'h04F);
        wr(4'h0, 32'h0D0);
        pins(1'b0, 1'b1, "R6 early reload");
        wt(1);
        rd(4'h0, 32'h07F, "R10 after early reload");

        // R6 reload exactly at the window
        wr(4'h0, 32'h0D0);
        wr(4'h4, 32'h04F);
        wt(3);
        wr(4'h0, 32'h0D0);
        pins(1'b0, 1'b0, "R6 reload at window");
        rd(4'h0, 32'h0D0, "R6 reload loaded");

        // R5 low value while active, then while inactive
        wr(4'h4, 32'h07F);
        wr(4'h0, 32'h0BF);
        pins(1'b0, 1'b1, "R5 low load active");
        wt(1);
        wr(4'h0, 32'h03F);
        pins(1'b0, 1'b0, "R5 low load inactive");
        rd(4'h0, 32'h03F, "R5 value loaded");

        // R8 hardware set and software clear on the same edge
        wr(4'h0, 32'h041);
        wt(3);
        wr(4'h8, 32'h0);
        rd(4'h8, 32'h1, "R8 set wins over clear");
        wr(4'h8, 32'h0);
        rd(4'h8, 32'h0, "R8 later clear");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule